// File: doc/BRIEF.md
# One-Wire Bus Master Engine

This block produces the timed waveforms a master needs on a single-wire, open-drain bus with a pull-up. It runs one operation per command. A bus reset drives the line low, releases it, and checks whether any device answers. A write slot sends one bit. A read slot issues a short low pulse and then samples the level the device leaves on the line. Every duration is counted in microsecond ticks, which a parameterised divider derives from the system clock. Each operation can run at standard speed or at overdrive speed, and the timing set is picked per command.

A controller supplies an operation code, a write bit and a speed flag together with a valid strobe. The engine raises busy for the whole slot. At the end it gives a one-cycle done pulse with the result bit: the sampled read bit, or the presence flag after a reset. The pad side works in one of two ways. In level mode the output enable stays on and the output level carries the waveform. In direction mode the output value stays at 0 and the enable is switched, so that the pull-up raises the line whenever the enable is off.

Top module: `onew_master`

## Requirements
- R1: After reset, busy, done and result are 0 and the line is released: in level mode (pad_mode=0) bus_o=1 and bus_oe=1, and in direction mode (pad_mode=1) bus_oe=0.
- R2: A reset command (cmd_op=2'b00) holds the line low for 480 µs at standard speed (cmd_fast=0) or 48 µs at overdrive (cmd_fast=1). It then releases the line and samples it 70 µs or 7 µs later. A sampled 0 gives result 0 (device present) and a sampled 1 gives result 1.
- R3: After the reset sample, the engine waits a further 1000 µs at standard speed or 40 µs at overdrive before it raises done.
- R4: A write command (cmd_op=2'b01) with cmd_wbit=1 drives the line low for 6 µs and then releases it for 64 µs at standard speed. At overdrive it uses 1 µs low and 10 µs released.
- R5: A write command with cmd_wbit=0 drives the line low for 60 µs and then releases it for 10 µs at standard speed. At overdrive it uses 8 µs low and 5 µs released. A write returns result 0.
- R6: A read command (cmd_op=2'b10) drives the line low for 6 µs and samples the line 9 µs after release, then waits out a further 55 µs. At overdrive it drives the line low for 1 µs, samples at the first tick after release (1 µs), and then waits 8 µs.
- R7: In level mode bus_oe is always 1 and the low phase shows as bus_o=0. In direction mode bus_o is always 0 and the low phase shows as bus_oe=1.
- R8: A cmd_valid strobe while busy is ignored, and so is the reserved code cmd_op=2'b11. Neither one starts, lengthens or changes a slot.
- R9: Operation, write bit and speed are captured when a command is accepted. Changing them during a slot has no effect on that slot.
- R10: done is a single-cycle pulse in the first cycle in which busy is low after a slot, and result is valid in that cycle. result then holds until the next accepted command, which clears it to 0.
- R11: bus_i passes through a two-flop synchroniser. The sample is taken on the microsecond tick at which the sample time expires, so a level present on bus_i in only one clock cycle, two cycles before that edge, decides the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_op | input | 2 | 00 reset, 01 write, 10 read, 11 reserved |
| cmd_wbit | input | 1 | Bit sent by a write slot |
| cmd_fast | input | 1 | 1 selects overdrive timing |
| pad_mode | input | 1 | 0 level drive, 1 direction drive |
| busy | output | 1 | Slot in progress |
| done | output | 1 | One-cycle end-of-slot pulse |
| result | output | 1 | Read bit or presence flag (0 = present) |
| bus_i | input | 1 | Line level from the pad |
| bus_o | output | 1 | Pad output value |
| bus_oe | output | 1 | Pad output enable |

## Verification
The assertions assume that pad_mode changes only while the engine is idle. They also assume the divider ratio is at least 2, so that a tick never lands on the acceptance edge. bus_i may change at any time, and nothing is assumed about it. The bench changes pad_mode only between slots and runs with a ratio of 4 clocks per microsecond, so every duration becomes a short cycle count it can predict exactly. The bench drives the modelled device response only in the released part of a slot, so the line never sees a device pulling low against a master phase that is already low.

// File: rtl/onew_pkg.sv
package onew_pkg;

  localparam int unsigned US_W = 11;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_NONE  = 2'b11
  } onew_op_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_LOW  = 2'b01,
    PH_MID  = 2'b10,
    PH_TAIL = 2'b11
  } onew_phase_e;

  // standard speed durations, microseconds
  localparam int unsigned STD_RST_LOW  = 480;
  localparam int unsigned STD_RST_SMP  = 70;
  localparam int unsigned STD_RST_REC  = 1000;
  localparam int unsigned STD_W1_LOW   = 6;
  localparam int unsigned STD_W1_REL   = 64;
  localparam int unsigned STD_W0_LOW   = 60;
  localparam int unsigned STD_W0_REL   = 10;
  localparam int unsigned STD_RD_LOW   = 6;
  localparam int unsigned STD_RD_SMP   = 9;
  localparam int unsigned STD_RD_TAIL  = 55;

  // overdrive durations, microseconds
  localparam int unsigned OVD_RST_LOW  = 48;
  localparam int unsigned OVD_RST_SMP  = 7;
  localparam int unsigned OVD_RST_REC  = 40;
  localparam int unsigned OVD_W1_LOW   = 1;
  localparam int unsigned OVD_W1_REL   = 10;
  localparam int unsigned OVD_W0_LOW   = 8;
  localparam int unsigned OVD_W0_REL   = 5;
  localparam int unsigned OVD_RD_LOW   = 1;
  localparam int unsigned OVD_RD_SMP   = 1;
  localparam int unsigned OVD_RD_TAIL  = 8;

  // Length in microseconds of one phase of one slot; 0 means the phase is skipped.
  function automatic logic [US_W-1:0] phase_us(onew_op_e op, logic wbit, logic fast,
                                               onew_phase_e ph);
    int unsigned v;
    v = 0;
    unique case (op)
      OP_RESET: begin
        if (ph == PH_LOW)  v = fast ? OVD_RST_LOW : STD_RST_LOW;
        if (ph == PH_MID)  v = fast ? OVD_RST_SMP : STD_RST_SMP;
        if (ph == PH_TAIL) v = fast ? OVD_RST_REC : STD_RST_REC;
      end
      OP_WRITE: begin
        if (ph == PH_LOW)
          v = wbit ? (fast ? OVD_W1_LOW : STD_W1_LOW) : (fast ? OVD_W0_LOW : STD_W0_LOW);
        if (ph == PH_MID)
          v = wbit ? (fast ? OVD_W1_REL : STD_W1_REL) : (fast ? OVD_W0_REL : STD_W0_REL);
      end
      OP_READ: begin
        if (ph == PH_LOW)  v = fast ? OVD_RD_LOW  : STD_RD_LOW;
        if (ph == PH_MID)  v = fast ? OVD_RD_SMP  : STD_RD_SMP;
        if (ph == PH_TAIL) v = fast ? OVD_RD_TAIL : STD_RD_TAIL;
      end
      default: v = 0;
    endcase
    return v[US_W-1:0];
  endfunction

  // Whether an operation samples the line at the end of its middle phase.
  function automatic logic op_samples(onew_op_e op);
    return (op == OP_RESET) || (op == OP_READ);
  endfunction

endpackage

// File: rtl/onew_tick_gen.sv
module onew_tick_gen #(
  parameter int unsigned DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick = (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pre_q <= '0;
    else if (clear) pre_q <= '0;
    else if (tick)  pre_q <= '0;
    else            pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/onew_sync.sv
module onew_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/onew_slot_seq.sv
module onew_slot_seq
  import onew_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  onew_op_e    op_in,
  input  logic        wbit_in,
  input  logic        fast_in,
  input  logic        tick,
  input  logic        line_s,
  output onew_phase_e phase,
  output onew_op_e    op_q,
  output logic        busy,
  output logic        done,
  output logic        result,
  output logic        slot_end,
  output logic        sample_now
);
  logic [US_W-1:0] cnt_q;
  logic            wbit_q, fast_q;
  logic            ph_done;
  onew_phase_e     nxt;

  assign busy    = (phase != PH_IDLE);
  assign ph_done = busy && tick && (cnt_q == US_W'(1));

  always_comb begin
    unique case (phase)
      PH_LOW:  nxt = PH_MID;
      PH_MID:  nxt = (phase_us(op_q, wbit_q, fast_q, PH_TAIL) != '0) ? PH_TAIL : PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  assign sample_now = ph_done && (phase == PH_MID) && op_samples(op_q);
  assign slot_end   = ph_done && (nxt == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      op_q   <= OP_NONE;
      wbit_q <= 1'b0;
      fast_q <= 1'b0;
      cnt_q  <= '0;
      done   <= 1'b0;
      result <= 1'b0;
    end else begin
      done <= slot_end;
      if (start) begin
        phase  <= PH_LOW;
        op_q   <= op_in;
        wbit_q <= wbit_in;
        fast_q <= fast_in;
        cnt_q  <= phase_us(op_in, wbit_in, fast_in, PH_LOW);
        result <= 1'b0;
      end else if (busy && tick) begin
        if (ph_done) begin
          phase <= nxt;
          cnt_q <= phase_us(op_q, wbit_q, fast_q, nxt);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        if (sample_now) result <= line_s;
      end
    end
  end
endmodule

// File: rtl/onew_master.sv
module onew_master
  import onew_pkg::*;
#(
  parameter int unsigned CLK_PER_US  = 50,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_wbit,
  input  logic       cmd_fast,
  input  logic       pad_mode,
  output logic       busy,
  output logic       done,
  output logic       result,
  input  logic       bus_i,
  output logic       bus_o,
  output logic       bus_oe
);
  onew_op_e    op_in;
  onew_op_e    op_cur;
  onew_phase_e phase_w;
  logic        accept_w;
  logic        tick_w;
  logic        line_s_w;
  logic        slot_end_w;
  logic        sample_w;
  logic        drive_low_w;
  logic [1:0]  op_q_w;

  assign op_in    = onew_op_e'(cmd_op);
  assign accept_w = cmd_valid && !busy && (op_in != OP_NONE);

  onew_tick_gen #(.DIV(CLK_PER_US)) tick_i (
    .clk(clk), .rst_n(rst_n), .clear(accept_w), .tick(tick_w)
  );

  onew_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(bus_i), .q(line_s_w)
  );

  onew_slot_seq seq_i (
    .clk(clk), .rst_n(rst_n), .start(accept_w),
    .op_in(op_in), .wbit_in(cmd_wbit), .fast_in(cmd_fast),
    .tick(tick_w), .line_s(line_s_w),
    .phase(phase_w), .op_q(op_cur),
    .busy(busy), .done(done), .result(result),
    .slot_end(slot_end_w), .sample_now(sample_w)
  );

  assign op_q_w      = op_cur;
  assign drive_low_w = (phase_w == PH_LOW);
  assign bus_o       = pad_mode ? 1'b0 : !drive_low_w;
  assign bus_oe      = pad_mode ? drive_low_w : 1'b1;
endmodule

// File: rtl/onew_master_chk.sv
module onew_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pad_mode,
  input logic       busy,
  input logic       done,
  input logic       result,
  input logic       bus_o,
  input logic       bus_oe,
  input logic       tick,
  input logic       slot_end,
  input logic       sample_now,
  input logic [1:0] op_q
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !slot_end) |=> busy);
  // R2
  end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n) slot_end |-> tick);
  // R11
  sample_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n) sample_now |-> tick);
  // R7
  level_mode_chk: assert property (@(posedge clk) disable iff (!rst_n) !pad_mode |-> bus_oe);
  // R7
  dir_mode_chk: assert property (@(posedge clk) disable iff (!rst_n) pad_mode |-> !bus_o);
  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pad_mode ? !bus_oe : bus_o));
  // R9
  op_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op_q));
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> $stable(result));
endmodule

bind onew_master onew_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pad_mode(pad_mode), .busy(busy), .done(done),
  .result(result), .bus_o(bus_o), .bus_oe(bus_oe), .tick(tick_w),
  .slot_end(slot_end_w), .sample_now(sample_w), .op_q(op_q_w)
);

// File: tb/onew_master_tb.sv
module onew_master_tb_top;
  localparam int US = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic cmd_wbit = 1'b0;
  logic cmd_fast = 1'b0;
  logic pad_mode = 1'b0;
  logic busy, done, result, bus_i, bus_o, bus_oe;
  logic dev_low = 1'b0;
  logic master_low;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;

  assign master_low = pad_mode ? bus_oe : !bus_o;
  assign bus_i = !(master_low || dev_low);

  onew_master #(.CLK_PER_US(US)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wbit(cmd_wbit), .cmd_fast(cmd_fast), .pad_mode(pad_mode),
    .busy(busy), .done(done), .result(result),
    .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Runs one slot; counts low and released-busy cycles at negedges.
  task automatic run_slot(input logic [1:0] op, input logic wb, input logic fast,
                          input logic dev_answer, input int samp_us, input logic disturb,
                          output int lo, output int rel, output logic res,
                          output logic res_start, output int mode_bad);
    int guard;
    @(negedge clk);
    cmd_op = op; cmd_wbit = wb; cmd_fast = fast; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    res_start = result;
    lo = 0; rel = 0; guard = 0; mode_bad = 0;
    while (!done && guard < 30000) begin
      guard++;
      if (pad_mode ? bus_o : !bus_oe) mode_bad++;
      dev_low = 1'b0;
      if (master_low) lo++;
      else if (busy) begin
        rel++;
        if (dev_answer && rel == samp_us * US - 2) dev_low = 1'b1;
      end
      if (disturb && lo == 2) begin
        cmd_valid = 1'b1; cmd_op = 2'b10; cmd_fast = !fast; cmd_wbit = !wb;
      end
      if (disturb && lo == 3) cmd_valid = 1'b0;
      @(negedge clk);
    end
    dev_low = 1'b0;
    cmd_valid = 1'b0;
    res = result;
    chk(guard < 30000, "R10", "done seen", guard, 0);
    chk(!busy, "R10", "busy low with done", busy, 0);
    @(negedge clk);
    chk(!done, "R10", "done one cycle", done, 0);
  endtask

  task automatic t_reset_state();
    chk(!busy && !done && !result, "R1", "idle outputs", {busy, done, result}, 0);
    chk(bus_o && bus_oe, "R1", "level released", {bus_o, bus_oe}, 3);
    pad_mode = 1'b1; #1;
    chk(!bus_oe && !bus_o, "R1", "dir released", {bus_o, bus_oe}, 0);
    pad_mode = 1'b0;
  endtask

  task automatic t_bus_reset(input logic fast, input logic present);
    int lo, rel, mb; logic res, rs;
    int low_us = fast ? 48 : 480;
    int smp_us = fast ? 7 : 70;
    int rec_us = fast ? 40 : 1000;
    run_slot(2'b00, 1'b0, fast, present, smp_us, 1'b0, lo, rel, res, rs, mb);
    chk(lo == low_us * US, "R2", "reset low", lo, low_us * US);
    chk(rel == (smp_us + rec_us) * US, "R3", "reset release+recovery", rel,
        (smp_us + rec_us) * US);
    chk(res == !present, "R2", "presence", res, !present);
    chk(mb == 0, "R7", "pad mode shape", mb, 0);
  endtask

  task automatic t_write(input logic wb, input logic fast);
    int lo, rel, mb; logic res, rs;
    int low_us = wb ? (fast ? 1 : 6) : (fast ? 8 : 60);
    int rel_us = wb ? (fast ? 10 : 64) : (fast ? 5 : 10);
    run_slot(2'b01, wb, fast, 1'b0, 1, 1'b0, lo, rel, res, rs, mb);
    if (wb) begin
      chk(lo == low_us * US, "R4", "write1 low", lo, low_us * US);
      chk(rel == rel_us * US, "R4", "write1 release", rel, rel_us * US);
    end else begin
      chk(lo == low_us * US, "R5", "write0 low", lo, low_us * US);
      chk(rel == rel_us * US, "R5", "write0 release", rel, rel_us * US);
    end
    chk(res == 1'b0 && rs == 1'b0, "R5", "write result", res, 0);
    chk(mb == 0, "R7", "pad mode shape", mb, 0);
  endtask

  task automatic t_read(input logic fast, input logic dev_zero);
    int lo, rel, mb; logic res, rs;
    int low_us = fast ? 1 : 6;
    int smp_us = fast ? 1 : 9;
    int tail_us = fast ? 8 : 55;
    run_slot(2'b10, 1'b0, fast, dev_zero, smp_us, 1'b0, lo, rel, res, rs, mb);
    chk(lo == low_us * US, "R6", "read low", lo, low_us * US);
    chk(rel == (smp_us + tail_us) * US, "R6", "read release", rel, (smp_us + tail_us) * US);
    chk(res == !dev_zero, "R11", "read sample instant", res, !dev_zero);
  endtask

  task automatic t_dir_mode();
    pad_mode = 1'b1;
    t_write(1'b0, 1'b0);
    t_bus_reset(1'b1, 1'b1);
    pad_mode = 1'b0;
  endtask

  task automatic t_ignore_and_latch();
    int lo, rel, mb; logic res, rs;
    // R8 and R9: strobe and input changes mid-slot must not alter a standard write0
    run_slot(2'b01, 1'b0, 1'b0, 1'b0, 1, 1'b1, lo, rel, res, rs, mb);
    chk(lo == 60 * US, "R9", "latched low", lo, 60 * US);
    chk(rel == 10 * US, "R8", "no extension", rel, 10 * US);
    for (int i = 0; i < 6; i++) @(negedge clk);
    chk(!busy, "R8", "no queued slot", busy, 0);
    cmd_op = 2'b00; cmd_fast = 1'b0; cmd_wbit = 1'b0;
    // R8: reserved code
    @(negedge clk); cmd_op = 2'b11; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (busy || !bus_o) begin
        chk(1'b0, "R8", "reserved op started", busy, 0);
        break;
      end
    end
    chk(!busy && bus_o, "R8", "reserved op idle", busy, 0);
  endtask

  task automatic t_result_hold();
    int lo, rel, mb; logic res, rs;
    run_slot(2'b10, 1'b0, 1'b1, 1'b0, 1, 1'b0, lo, rel, res, rs, mb);
    for (int i = 0; i < 10; i++) @(negedge clk);
    chk(result == 1'b1, "R10", "result holds", result, 1);
    run_slot(2'b01, 1'b1, 1'b1, 1'b0, 1, 1'b0, lo, rel, res, rs, mb);
    chk(rs == 1'b0, "R10", "result cleared at start", rs, 0);
  endtask

  initial begin
    #(20 * 190000);
    n_errors++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_bus_reset(1'b0, 1'b1);
    t_bus_reset(1'b0, 1'b0);
    t_bus_reset(1'b1, 1'b1);
    t_bus_reset(1'b1, 1'b0);
    t_write(1'b1, 1'b0);
    t_write(1'b1, 1'b1);
    t_write(1'b0, 1'b0);
    t_write(1'b0, 1'b1);
    t_read(1'b0, 1'b1);
    t_read(1'b0, 1'b0);
    t_read(1'b1, 1'b1);
    t_read(1'b1, 1'b0);
    t_dir_mode();
    t_ignore_and_latch();
    t_result_hold();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule